// File: doc/BRIEF.md
# Serial ADC Conversion Read Sequencer

This block runs one complete conversion read from a serial 8-channel converter over a four-wire SPI-style link, each time it is asked. A one-cycle start request latches a command word and its bit length from configuration inputs. The block then pulls chip-select low and shifts the command out most significant bit first. It follows the command with two idle clocks, captures the conversion result most significant bit first, and issues a run of trailing clocks whose returned data is thrown away. After that it releases chip-select and pulses a valid strobe for one system clock.

The serial clock idles low. Each half of its period lasts `HALF_DIV` system clocks. The result width defaults to 10 bits and can be set to 12, with a matching change to the trailing clock count. The command width limit, the idle clock count and the trailing clock count are all parameters.

Top module: `adc_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `cs_no` is 1, and `sclk_o`, `sdo_o` and `valid_o` are 0.
- R2: `cs_no` goes low in the cycle after an accepted start and stays low until the last serial clock pulse has fallen. `sclk_o` is never high while `cs_no` is high, and `sclk_o` is low in the cycle in which `cs_no` returns high.
- R3: The command is the low `cmd_len_i` bits of `cmd_i`, with a length from 1 to `CMD_MAX_W`, latched at start. It is sent on the first `cmd_len_i` pulses, bit `cmd_len_i-1` first. `sdo_o` carries a bit from the start of that bit's low half until the pulse falls.
- R4: `sclk_o` idles low. Every high phase lasts exactly `HALF_DIV` system clocks, and every low phase inside a transaction also lasts exactly `HALF_DIV` system clocks.
- R5: A transaction has exactly N = cmd_len + `NULL_CLKS` + `RES_W` + `TAIL_CLKS` serial clock pulses. The defaults are 2 idle clocks, a 10-bit result and 9 trailing clocks.
- R6: The result is built most significant bit first from `sdi_i`, sampled on the system clock edge at which `sclk_o` rises, on pulses cmd_len+`NULL_CLKS` through cmd_len+`NULL_CLKS`+`RES_W`-1, where pulses are counted from 0. `sdi_i` on all other pulses has no effect on `result_o`.
- R7: `valid_o` is high for exactly one cycle, 2·N·`HALF_DIV`+1 clock edges after the edge that accepted the start. `cs_no` is high in that cycle and in the cycle before it. `result_o` holds the value until the next transaction completes.
- R8: A start request is accepted only when the block is idle. A start request during a transaction, including its release and strobe cycles, changes neither its timing nor its result, and it does not begin a further transaction.
- R9: `sdo_o` is 0 whenever no command bit is being shifted: while `cs_no` is high, and on every pulse after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion read (accepted when idle) |
| cmd_i | input | CMD_MAX_W | Command word, right-aligned |
| cmd_len_i | input | $clog2(CMD_MAX_W+1) | Number of command bits to send |
| sdi_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Chip-select, active low |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the converter |
| result_o | output | RES_W | Last captured conversion result |
| valid_o | output | 1 | One-cycle strobe: result_o updated |

## Verification
All timing is counted from the clock edge that samples the start request. The first rising edge of the serial clock falls on edge `HALF_DIV`, the last falling edge on edge 2·N·`HALF_DIV`, chip-select rises on that same edge, and the strobe and new result appear one edge later. The bench counts falling system clock edges from the start edge until it sees the strobe, and compares that count with 2·N·`HALF_DIV`+1, worked out from the command length in use. A converter model counts serial clock rising edges, captures `sdo_o` and drives `sdi_i` in step with that count, and it puts alternating filler on the pulses that must be ignored. The bench also checks the pulse total, the captured command and the result, and it reads every output at negedges so that no sample sits on an active edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_NULL,
    PH_CAP,
    PH_TAIL,
    PH_REL,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/adc_seq_half_timer.sv
module adc_seq_half_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end

  generate
    if (HALF_DIV > 1) begin : g_gap
      // half phase longer than one cycle: ticks never back to back
      assert_half_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CMD_MAX_W = 8,
  parameter int RES_W     = 10,
  parameter int NULL_CLKS = 2,
  parameter int TAIL_CLKS = 9,
  parameter int LEN_W     = $clog2(CMD_MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             tick_i,
  output phase_e           phase_o,
  output logic             run_o,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             valid_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             sample_o
);
  localparam int MAX_AB = (CMD_MAX_W > RES_W) ? CMD_MAX_W : RES_W;
  localparam int MAX_CD = (NULL_CLKS > TAIL_CLKS) ? NULL_CLKS : TAIL_CLKS;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int BW     = $clog2(MAXC + 1);

  phase_e           phase_q;
  logic [BW-1:0]    bit_cnt_q;
  logic [BW-1:0]    limit;
  logic [LEN_W-1:0] len_q;
  logic             sclk_q;
  logic             last_bit;
  phase_e           next_phase;

  always_comb begin
    unique case (phase_q)
      PH_CMD:  begin limit = BW'(len_q);     next_phase = PH_NULL; end
      PH_NULL: begin limit = BW'(NULL_CLKS); next_phase = PH_CAP;  end
      PH_CAP:  begin limit = BW'(RES_W);     next_phase = PH_TAIL; end
      PH_TAIL: begin limit = BW'(TAIL_CLKS); next_phase = PH_REL;  end
      default: begin limit = BW'(1);         next_phase = PH_IDLE; end
    endcase
  end

  assign last_bit = (bit_cnt_q == limit - BW'(1));
  assign run_o    = (phase_q == PH_CMD) || (phase_q == PH_NULL) ||
                    (phase_q == PH_CAP) || (phase_q == PH_TAIL);
  assign load_o   = (phase_q == PH_IDLE) && start_i;
  assign shift_o  = (phase_q == PH_CMD) && tick_i && sclk_q;
  assign sample_o = (phase_q == PH_CAP) && tick_i && !sclk_q;
  assign cs_no    = !run_o;
  assign valid_o  = (phase_q == PH_DONE);
  assign sclk_o   = sclk_q;
  assign phase_o  = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      len_q     <= '0;
      sclk_q    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q   <= PH_CMD;
          len_q     <= len_i;
          bit_cnt_q <= '0;
          sclk_q    <= 1'b0;
        end
        PH_REL:  phase_q <= PH_DONE;
        PH_DONE: phase_q <= PH_IDLE;
        default: if (tick_i) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (last_bit) begin
              bit_cnt_q <= '0;
              phase_q   <= next_phase;
            end else begin
              bit_cnt_q <= bit_cnt_q + BW'(1);
            end
          end
        end
      endcase
    end
  end

  assert_sclk_framed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> !cs_no);
  assert_valid_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_valid_after_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cs_no && $past(cs_no)));
  assert_busy_keeps_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && start_i) |=> $stable(len_q));
endmodule

// File: rtl/adc_seq_cmd_shifter.sv
module adc_seq_cmd_shifter #(
  parameter int CMD_MAX_W = 8,
  parameter int LEN_W     = $clog2(CMD_MAX_W + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 shift_i,
  input  logic                 active_i,
  input  logic [CMD_MAX_W-1:0] cmd_i,
  input  logic [LEN_W-1:0]     len_i,
  output logic                 sdo_o
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(CMD_MAX_W);

  logic [CMD_MAX_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= cmd_i << (FULL - len_i);  // left-align first bit
    else if (shift_i) sr_q <= {sr_q[CMD_MAX_W-2:0], 1'b0};
  end

  assign sdo_o = active_i && sr_q[CMD_MAX_W-1];
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             commit_i,
  input  logic             sdi_i,
  output logic [RES_W-1:0] result_o
);
  logic [RES_W-1:0] cap_q;
  logic [RES_W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      res_q <= '0;
    end else begin
      if (sample_i) cap_q <= {cap_q[RES_W-2:0], sdi_i};
      if (commit_i) res_q <= cap_q;
    end
  end

  assign result_o = res_q;

  assert_result_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> $stable(res_q));
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int CMD_MAX_W = 8,
  parameter int RES_W     = 10,
  parameter int NULL_CLKS = 2,
  parameter int TAIL_CLKS = 9,
  parameter int HALF_DIV  = 2,
  parameter int LEN_W     = $clog2(CMD_MAX_W + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [CMD_MAX_W-1:0] cmd_i,
  input  logic [LEN_W-1:0]     cmd_len_i,
  input  logic                 sdi_i,
  output logic                 cs_no,
  output logic                 sclk_o,
  output logic                 sdo_o,
  output logic [RES_W-1:0]     result_o,
  output logic                 valid_o
);
  phase_e phase;
  logic   run, tick, load, shift, sample;

  adc_seq_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  adc_seq_ctrl #(
    .CMD_MAX_W (CMD_MAX_W),
    .RES_W     (RES_W),
    .NULL_CLKS (NULL_CLKS),
    .TAIL_CLKS (TAIL_CLKS),
    .LEN_W     (LEN_W)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .len_i    (cmd_len_i),
    .tick_i   (tick),
    .phase_o  (phase),
    .run_o    (run),
    .sclk_o   (sclk_o),
    .cs_no    (cs_no),
    .valid_o  (valid_o),
    .load_o   (load),
    .shift_o  (shift),
    .sample_o (sample)
  );

  adc_seq_cmd_shifter #(.CMD_MAX_W(CMD_MAX_W), .LEN_W(LEN_W)) u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .shift_i  (shift),
    .active_i (phase == PH_CMD),
    .cmd_i    (cmd_i),
    .len_i    (cmd_len_i),
    .sdo_o    (sdo_o)
  );

  adc_seq_capture #(.RES_W(RES_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .commit_i (phase == PH_REL),
    .sdi_i    (sdi_i),
    .result_o (result_o)
  );

  assert_sdo_framed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_o |-> !cs_no);
  assert_cs_release_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> !sclk_o);
  assert_sdo_steady_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |=> (!sclk_o || $stable(sdo_o)));
endmodule

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  localparam int CMD_MAX_W = 8;
  localparam int RES_W     = 10;
  localparam int NULL_CLKS = 2;
  localparam int TAIL_CLKS = 9;
  localparam int HALF_DIV  = 2;
  localparam int LEN_W     = $clog2(CMD_MAX_W + 1);

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 start_i = 1'b0;
  logic [CMD_MAX_W-1:0] cmd_i = '0;
  logic [LEN_W-1:0]     cmd_len_i = '0;
  logic                 sdi;
  logic                 cs_no, sclk_o, sdo_o, valid_o;
  logic [RES_W-1:0]     result_o;

  int errors = 0;
  int checks = 0;
  bit timeout = 0;

  always #5 clk = ~clk;

  adc_seq #(
    .CMD_MAX_W(CMD_MAX_W), .RES_W(RES_W), .NULL_CLKS(NULL_CLKS),
    .TAIL_CLKS(TAIL_CLKS), .HALF_DIV(HALF_DIV)
  ) u_adc_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cmd_i(cmd_i),
    .cmd_len_i(cmd_len_i), .sdi_i(sdi), .cs_no(cs_no), .sclk_o(sclk_o),
    .sdo_o(sdo_o), .result_o(result_o), .valid_o(valid_o)
  );

  // converter model
  logic [RES_W-1:0]     adc_val = '0;
  int                   cur_len = 5;
  int                   rcnt = 0;
  int                   last_pulses = 0;
  logic [CMD_MAX_W-1:0] rx_cmd = '0;
  int                   sdo_tail_err = 0;
  int                   sdo_idle_err = 0;
  int                   cs_err = 0;
  int                   per_err = 0;
  int                   hi_run = 0;
  int                   lo_run = 0;

  always_comb begin
    int j;
    j = rcnt - cur_len - NULL_CLKS;
    if (j >= 0 && j < RES_W) sdi = adc_val[RES_W-1-j];
    else                     sdi = rcnt[0];  // filler that must be ignored
  end

  always @(posedge sclk_o or posedge cs_no) begin
    if (cs_no) begin
      last_pulses <= rcnt;
      rcnt <= 0;
    end else begin
      if (rcnt < cur_len) rx_cmd <= {rx_cmd[CMD_MAX_W-2:0], sdo_o};
      else if (sdo_o) sdo_tail_err <= sdo_tail_err + 1;
      rcnt <= rcnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      if (cs_no && sdo_o) sdo_idle_err <= sdo_idle_err + 1;
      if (cs_no && sclk_o) cs_err <= cs_err + 1;
      if (sclk_o) begin
        if (lo_run != 0 && lo_run != HALF_DIV) per_err <= per_err + 1;
        lo_run <= 0;
        hi_run <= hi_run + 1;
      end else begin
        if (hi_run != 0 && hi_run != HALF_DIV) per_err <= per_err + 1;
        hi_run <= 0;
        // count in-frame low time only after the first rise
        if (!cs_no && rcnt > 0) lo_run <= lo_run + 1;
        else lo_run <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [CMD_MAX_W-1:0] cmd, input int len,
                         input logic [RES_W-1:0] val, input bit poke);
    int count, n_exp, e_sdo, e_cs, e_per;
    logic [CMD_MAX_W-1:0] mask;
    bit cs_first;
    mask    = CMD_MAX_W'((1 << len) - 1);
    n_exp   = len + NULL_CLKS + RES_W + TAIL_CLKS;
    e_sdo   = sdo_tail_err + sdo_idle_err;
    e_cs    = cs_err;
    e_per   = per_err;
    cur_len = len;
    adc_val = val;
    @(negedge clk);
    cmd_i = cmd;
    cmd_len_i = LEN_W'(len);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    count = 0;
    cs_first = 1'b0;
    while (!valid_o && count < 5000) begin
      @(negedge clk);
      count++;
      if (count == 1) cs_first = !cs_no;
      if (poke && count == 9) begin
        start_i = 1'b1;
        cmd_len_i = LEN_W'(1);
        cmd_i = ~cmd;
      end
      if (poke && count == 10) start_i = 1'b0;
      if (poke && count == 2 * n_exp * HALF_DIV) start_i = 1'b1;  // in release cycle
    end
    start_i = 1'b0;
    chk(cs_first, "R2 cs low after start", cs_first, 1);
    chk(count == 2 * n_exp * HALF_DIV + 1, "R7 strobe cycle", count, 2 * n_exp * HALF_DIV + 1);
    chk(cs_no, "R7 cs high at strobe", cs_no, 1);
    chk(result_o == val, "R6 result", result_o, val);
    chk((rx_cmd & mask) == (cmd & mask), "R3 command bits", rx_cmd & mask, cmd & mask);
    chk(last_pulses == n_exp, "R5 pulse count", last_pulses, n_exp);
    chk(sdo_tail_err + sdo_idle_err == e_sdo, "R9 sdo low outside command",
        sdo_tail_err + sdo_idle_err - e_sdo, 0);
    chk(cs_err == e_cs, "R2 sclk framed by cs", cs_err - e_cs, 0);
    chk(per_err == e_per, "R4 half period", per_err - e_per, 0);
    @(negedge clk);
    chk(!valid_o, "R7 strobe one cycle", valid_o, 0);
    chk(result_o == val, "R7 result held", result_o, val);
    if (poke) begin
      bit stayed;
      stayed = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!cs_no) stayed = 1'b0;
      end
      chk(stayed, "R8 no extra transaction", stayed, 1);
    end
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    chk(cs_no && !sclk_o && !sdo_o && !valid_o, "R1 reset outputs in reset",
        {cs_no, sclk_o, sdo_o, valid_o}, 4'b1000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cs_no && !sclk_o && !sdo_o && !valid_o, "R1 reset outputs after release",
        {cs_no, sclk_o, sdo_o, valid_o}, 4'b1000);
    // default command: start, single-ended, channel 2
    run_txn(8'b0001_1010, 5, 10'h2C5, 1'b0);
    run_txn(8'b0001_1010, 5, 10'h13A, 1'b1);
    for (int len = 1; len <= CMD_MAX_W; len++) begin
      for (int v = 0; v < 4; v++) begin
        logic [RES_W-1:0] val;
        logic [CMD_MAX_W-1:0] cmd;
        case (v)
          0: val = '0;
          1: val = '1;
          2: val = RES_W'(10'h2AA);
          default: val = RES_W'(len * 71 + 5);
        endcase
        cmd = CMD_MAX_W'(8'hA5 ^ (len * 37));
        run_txn(cmd, len, val, (v == 3));
      end
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) chk(1'b0, "R7 watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule